// File: doc/BRIEF.md
# Chained-Device Select and Next-Free Arbitration

In a system built from several identical devices wired in a chain, every device shares the same command and data bus. This block gives each device an identity and decides whether it should act on the current bus traffic. Each device keeps two 16-bit registers: a chain address, which is its own identity, and a target register, which names the device that the host wants to talk to. Both registers are written in two bus steps. First the external decoder pulses a load strobe for one of them. The next data-write cycle then supplies the value.

The device is selected when the target register holds the same value as its chain address. If the target register holds the all-ones value, every device in the chain is selected at the same time. In that broadcast case the read qualifier stays low, so that no two devices drive the bus together. The block also takes part in the full-flag chain and decides which device answers a next-free read. With the compare-enable input low, the answer comes from the first device in the chain that still has room. With the compare-enable input high, the answer comes from the device that the target register selects.

A small state machine tracks the pending load. `DSEL_IDLE` moves to `DSEL_WAIT_PAGE` on a chain-address load strobe, and to `DSEL_WAIT_SEL` on a target load strobe. A waiting state goes back to `DSEL_IDLE` when the data write arrives. A fresh load strobe moves it straight to the wait state that strobe names. A soft reset in any state forces `DSEL_IDLE`.

Top module: `dsel_chain_top`

## Requirements
- R1: After the hard reset, both the chain address and the target register are 0 and the state machine is idle. So `selected` and `read_ok` are 1 and `sel_value` is 0x0000.
- R2: A `cmd_ld_page` pulse, followed in a later cycle by a `wr_valid` cycle, loads `wr_data` into the chain address. The new value takes effect from the clock edge that samples `wr_valid`.
- R3: A pending chain-address write whose data is 0xFFFF completes the load sequence but leaves the chain address unchanged.
- R4: A `cmd_ld_sel` pulse, followed in a later cycle by a `wr_valid` cycle, loads `wr_data` into the target register. The target register can always be read on `sel_value`.
- R5: `selected` is 1 exactly when the target register equals the chain address or holds 0xFFFF.
- R6: `read_ok` is 1 exactly when the target register equals the chain address and is not 0xFFFF. A broadcast never allows a read.
- R7: `full_out_n` is 0 exactly when `full_in_n` is 0 and `local_full` is 1.
- R8: With `enable_cmp` at 0, `nf_respond` equals `nf_read` AND `full_in_n`==0 AND `local_full`==0.
- R9: With `enable_cmp` at 1, `nf_respond` equals `nf_read` AND `read_ok`.
- R10: `sw_reset` returns the state machine to idle and discards any pending load. It changes neither register, even when `wr_valid` arrives in the same cycle.
- R11: A `wr_valid` cycle while idle with no load strobe changes neither register.
- R12: A `wr_valid` cycle in a wait state, together with a new load strobe, both completes the pending load and arms the new one. If both strobes are present, `cmd_ld_page` takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| sw_reset | input | 1 | Soft reset; clears the pending-load state only |
| cmd_ld_page | input | 1 | Decoder strobe: next write loads the chain address |
| cmd_ld_sel | input | 1 | Decoder strobe: next write loads the target register |
| wr_valid | input | 1 | Data-write cycle on the bus |
| wr_data | input | 16 | Data-write value |
| enable_cmp | input | 1 | 0 = full-flag chain arbitration, 1 = arbitration by target register |
| full_in_n | input | 1 | Low when every upstream device is full (tie low on the first device) |
| local_full | input | 1 | This device has no free entry |
| nf_read | input | 1 | A next-free access is in progress |
| selected | output | 1 | Device is addressed (directly or by broadcast) |
| read_ok | output | 1 | Device is addressed and may drive read data |
| sel_value | output | 16 | Read-back of the target register |
| full_out_n | output | 1 | Full flag passed to the next device, active low |
| nf_respond | output | 1 | This device answers the next-free access |

## Verification
Three things can land in the same clock edge. A pending load can complete, a new load strobe can arm the next register, and a soft reset can cancel everything. The bench provokes these overlaps in directed sequences: a write together with the opposite strobe, and a write together with a soft reset. It then compares the registers, as seen on `sel_value` and `selected`, against a bench model that gives the soft reset top priority. It also checks that a completing load still arms the new strobe. Random traffic biases the data toward a few shared values and the all-ones value, so that matches and broadcasts coincide with next-free reads in both arbitration modes.

// File: rtl/dsel_pkg.sv
package dsel_pkg;
    typedef enum logic [1:0] {
        DSEL_IDLE      = 2'd0,
        DSEL_WAIT_PAGE = 2'd1,
        DSEL_WAIT_SEL  = 2'd2
    } dsel_state_e;
endpackage

// File: rtl/dsel_cmd_fsm.sv
module dsel_cmd_fsm
    import dsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_reset,
    input  logic        cmd_page,
    input  logic        cmd_sel,
    input  logic        wr_valid,
    output dsel_state_e state_q,
    output logic        ld_page,
    output logic        ld_sel
);
    dsel_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DSEL_IDLE;
        else        state_q <= state_d;
    end

    // next state: soft reset wins, then a new strobe, then write completion
    always_comb begin
        state_d = state_q;
        if (sw_reset) begin
            state_d = DSEL_IDLE;
        end else begin
            unique case (state_q)
                DSEL_IDLE: begin
                    if (cmd_page)     state_d = DSEL_WAIT_PAGE;
                    else if (cmd_sel) state_d = DSEL_WAIT_SEL;
                end
                DSEL_WAIT_PAGE, DSEL_WAIT_SEL: begin
                    if (cmd_page)      state_d = DSEL_WAIT_PAGE;
                    else if (cmd_sel)  state_d = DSEL_WAIT_SEL;
                    else if (wr_valid) state_d = DSEL_IDLE;
                end
                default: state_d = DSEL_IDLE;
            endcase
        end
    end

    // outputs: load enables toward the register file
    always_comb begin
        ld_page = 1'b0;
        ld_sel  = 1'b0;
        if (!sw_reset && wr_valid) begin
            unique case (state_q)
                DSEL_WAIT_PAGE: ld_page = 1'b1;
                DSEL_WAIT_SEL:  ld_sel  = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dsel_regs.sv
module dsel_regs #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_page,
    input  logic              ld_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] page_q,
    output logic [ADDR_W-1:0] sel_q
);
    localparam logic [ADDR_W-1:0] ALL_ONES = '1;

    logic page_we;
    assign page_we = ld_page && (wr_data != ALL_ONES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            sel_q  <= '0;
        end else begin
            if (page_we) page_q <= wr_data;
            if (ld_sel)  sel_q  <= wr_data;
        end
    end
endmodule

// File: rtl/dsel_arbiter.sv
module dsel_arbiter #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] page_q,
    input  logic [ADDR_W-1:0] sel_q,
    input  logic              enable_cmp,
    input  logic              full_in_n,
    input  logic              local_full,
    input  logic              nf_read,
    output logic              selected,
    output logic              read_ok,
    output logic              full_out_n,
    output logic              nf_respond
);
    localparam logic [ADDR_W-1:0] ALL_ONES = '1;

    logic match, bcast, first_free;

    always_comb begin
        match      = (sel_q == page_q);
        bcast      = (sel_q == ALL_ONES);
        selected   = match || bcast;
        read_ok    = match && !bcast;
        full_out_n = !(!full_in_n && local_full);
        first_free = !full_in_n && !local_full;
        nf_respond = nf_read && (enable_cmp ? read_ok : first_free);
    end
endmodule

// File: rtl/dsel_chain_top.sv
module dsel_chain_top
    import dsel_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              cmd_ld_page,
    input  logic              cmd_ld_sel,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              enable_cmp,
    input  logic              full_in_n,
    input  logic              local_full,
    input  logic              nf_read,
    output logic              selected,
    output logic              read_ok,
    output logic [ADDR_W-1:0] sel_value,
    output logic              full_out_n,
    output logic              nf_respond
);
    dsel_state_e       state_q;
    logic              ld_page, ld_sel;
    logic [ADDR_W-1:0] page_q, sel_q;

    dsel_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_reset (sw_reset),
        .cmd_page (cmd_ld_page),
        .cmd_sel  (cmd_ld_sel),
        .wr_valid (wr_valid),
        .state_q  (state_q),
        .ld_page  (ld_page),
        .ld_sel   (ld_sel)
    );

    dsel_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_page (ld_page),
        .ld_sel  (ld_sel),
        .wr_data (wr_data),
        .page_q  (page_q),
        .sel_q   (sel_q)
    );

    dsel_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .page_q     (page_q),
        .sel_q      (sel_q),
        .enable_cmp (enable_cmp),
        .full_in_n  (full_in_n),
        .local_full (local_full),
        .nf_read    (nf_read),
        .selected   (selected),
        .read_ok    (read_ok),
        .full_out_n (full_out_n),
        .nf_respond (nf_respond)
    );

    assign sel_value = sel_q;
endmodule

// File: rtl/dsel_chain_chk.sv
module dsel_chain_chk
    import dsel_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_reset,
    input logic              cmd_ld_page,
    input logic              cmd_ld_sel,
    input logic              wr_valid,
    input logic              enable_cmp,
    input logic              full_in_n,
    input logic              local_full,
    input logic              nf_read,
    input logic              selected,
    input logic              read_ok,
    input logic [ADDR_W-1:0] sel_value,
    input logic              full_out_n,
    input logic              nf_respond,
    input logic [ADDR_W-1:0] page_q,
    input dsel_state_e       state_q
);
    localparam logic [ADDR_W-1:0] ALL_ONES = '1;

    assert_page_not_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        page_q != ALL_ONES);

    assert_read_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        read_ok |-> (selected && sel_value != ALL_ONES));

    assert_full_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_in_n && local_full) |-> !full_out_n);

    assert_nf_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_cmp && nf_respond) |-> (nf_read && !full_in_n && !local_full));

    assert_nf_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_cmp && nf_respond) |-> read_ok);

    assert_swrst_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> ($stable(sel_value) && $stable(page_q) && state_q == DSEL_IDLE));

    assert_idle_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DSEL_IDLE && wr_valid && !cmd_ld_page && !cmd_ld_sel && !sw_reset)
        |=> ($stable(sel_value) && $stable(page_q)));
endmodule

bind dsel_chain_top dsel_chain_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_reset    (sw_reset),
    .cmd_ld_page (cmd_ld_page),
    .cmd_ld_sel  (cmd_ld_sel),
    .wr_valid    (wr_valid),
    .enable_cmp  (enable_cmp),
    .full_in_n   (full_in_n),
    .local_full  (local_full),
    .nf_read     (nf_read),
    .selected    (selected),
    .read_ok     (read_ok),
    .sel_value   (sel_value),
    .full_out_n  (full_out_n),
    .nf_respond  (nf_respond),
    .page_q      (page_q),
    .state_q     (state_q)
);

// File: tb/tb_dsel_chain_top.sv
`timescale 1ns/1ps
module tb_dsel_chain_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_reset = 1'b0, cmd_ld_page = 1'b0, cmd_ld_sel = 1'b0, wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        enable_cmp = 1'b1, full_in_n = 1'b1, local_full = 1'b0, nf_read = 1'b0;
    logic        selected, read_ok, full_out_n, nf_respond;
    logic [15:0] sel_value;

    int checks = 0;
    int errors = 0;

    // bench model: 0 idle, 1 waiting for chain address, 2 waiting for target
    int          m_st = 0;
    logic [15:0] m_page = 16'h0000;
    logic [15:0] m_sel  = 16'h0000;

    always #2 clk = ~clk;

    dsel_chain_top dut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .cmd_ld_page(cmd_ld_page),
        .cmd_ld_sel(cmd_ld_sel), .wr_valid(wr_valid), .wr_data(wr_data),
        .enable_cmp(enable_cmp), .full_in_n(full_in_n), .local_full(local_full),
        .nf_read(nf_read), .selected(selected), .read_ok(read_ok),
        .sel_value(sel_value), .full_out_n(full_out_n), .nf_respond(nf_respond)
    );

    function automatic logic f_sel(logic [15:0] p, logic [15:0] s);
        return (s == p) || (s == 16'hFFFF);
    endfunction

    function automatic logic f_rok(logic [15:0] p, logic [15:0] s);
        return (s == p) && (s != 16'hFFFF);
    endfunction

    function automatic logic f_fo(logic fin, logic lf);
        return !(!fin && lf);
    endfunction

    function automatic logic f_nf(logic nf, logic cmp, logic fin, logic lf, logic rok);
        return nf && (cmp ? rok : (!fin && !lf));
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_update();
        if (sw_reset) begin
            m_st = 0;
        end else begin
            if (m_st != 0 && wr_valid) begin
                if (m_st == 1 && wr_data != 16'hFFFF) m_page = wr_data;
                if (m_st == 2) m_sel = wr_data;
            end
            if (cmd_ld_page)                 m_st = 1;
            else if (cmd_ld_sel)             m_st = 2;
            else if (m_st != 0 && wr_valid)  m_st = 0;
        end
    endtask

    task automatic step(bit sw, bit cp, bit cs, bit wv, logic [15:0] d,
                        bit cmp, bit fin, bit lf, bit nf);
        sw_reset = sw; cmd_ld_page = cp; cmd_ld_sel = cs; wr_valid = wv; wr_data = d;
        enable_cmp = cmp; full_in_n = fin; local_full = lf; nf_read = nf;
        #1;
        chk("R4 sel_value", sel_value, m_sel);
        chk("R5 selected", {15'b0, selected}, {15'b0, f_sel(m_page, m_sel)});
        chk("R6 read_ok", {15'b0, read_ok}, {15'b0, f_rok(m_page, m_sel)});
        chk("R7 full_out_n", {15'b0, full_out_n}, {15'b0, f_fo(fin, lf)});
        chk(cmp ? "R9 nf_respond" : "R8 nf_respond", {15'b0, nf_respond},
            {15'b0, f_nf(nf, cmp, fin, lf, f_rok(m_page, m_sel))});
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle_step();
        step(0, 0, 0, 0, 16'h0, 1, 1, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1480));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 sel_value", sel_value, 16'h0000);
        chk("R1 selected", {15'b0, selected}, 16'h1);
        chk("R1 read_ok", {15'b0, read_ok}, 16'h1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: chain address load with a gap before the data write
        step(0, 1, 0, 0, 16'h0, 1, 1, 0, 0);
        idle_step();
        step(0, 0, 0, 1, 16'h0005, 1, 1, 0, 0);
        #1 chk("R2 page loaded, target 0 no match", {15'b0, selected}, 16'h0);
        // R4: target load to 5
        step(0, 0, 1, 0, 16'h0, 1, 1, 0, 0);
        step(0, 0, 0, 1, 16'h0005, 1, 1, 0, 0);
        #1 chk("R4 target read back", sel_value, 16'h0005);
        chk("R5 match after loads", {15'b0, selected}, 16'h1);
        // R9: next-free by target
        step(0, 0, 0, 0, 16'h0, 1, 1, 1, 1);
        // R3: all-ones chain address ignored
        step(0, 1, 0, 0, 16'h0, 1, 1, 0, 0);
        step(0, 0, 0, 1, 16'hFFFF, 1, 1, 0, 0);
        #1 chk("R3 all-ones page ignored", {15'b0, read_ok}, 16'h1);
        // R6: broadcast selects but blocks read
        step(0, 0, 1, 0, 16'h0, 1, 1, 0, 0);
        step(0, 0, 0, 1, 16'hFFFF, 1, 1, 0, 0);
        #1 chk("R6 broadcast selected", {15'b0, selected}, 16'h1);
        chk("R6 broadcast no read", {15'b0, read_ok}, 16'h0);
        step(0, 0, 0, 0, 16'h0, 1, 1, 0, 1);
        #1 chk("R9 broadcast no nf answer", {15'b0, nf_respond}, 16'h0);
        // R8 / R7: chain arbitration corners
        step(0, 0, 0, 0, 16'h0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 16'h0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 16'h0, 0, 1, 0, 1);
        // R10: soft reset discards pending load, also with write in same cycle
        step(0, 0, 1, 0, 16'h0, 1, 1, 0, 0);
        step(1, 0, 0, 1, 16'h0005, 1, 1, 0, 0);
        step(0, 0, 0, 1, 16'h0005, 1, 1, 0, 0);
        #1 chk("R10 target kept after soft reset", sel_value, 16'hFFFF);
        // R11: write while idle ignored
        step(0, 0, 0, 1, 16'h0007, 1, 1, 0, 0);
        #1 chk("R11 idle write ignored", sel_value, 16'hFFFF);
        // R12: completion and re-arm in one cycle
        step(0, 0, 1, 0, 16'h0, 1, 1, 0, 0);
        step(0, 1, 0, 1, 16'h0009, 1, 1, 0, 0);
        step(0, 0, 0, 1, 16'h0009, 1, 1, 0, 0);
        #1 chk("R12 target loaded", sel_value, 16'h0009);
        chk("R12 page loaded after re-arm", {15'b0, read_ok}, 16'h1);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            case ($urandom % 4)
                0: d = 16'h0003;
                1: d = 16'h0009;
                2: d = 16'hFFFF;
                default: d = 16'($urandom);
            endcase
            step(($urandom % 16) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
                 ($urandom % 3) == 0, d, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
        end
        idle_step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule